// File: doc/BRIEF.md
# ECC Error Capture Logger

This block sits next to a cache data store whose 128-bit lanes are each guarded by a 10-bit single-error-correct, double-error-detect check word. A read returns half a cacheline, which is four lanes. For each such read the decoder hands this block a valid strobe, the half-cacheline index, the set number, a per-lane syndrome, and per-lane single-error and double-error indications. The block keeps a sticky flag for each error class and one failure record. The record holds the location and the four syndromes. It raises two interrupts, and each one is gated by its own enable bit.

Capture is owned by a three-state machine. The states are `S_EMPTY` (no flag held), `S_SEC` (single-error flag held, no double held) and `S_DED` (double-error flag held). The transitions are:
- `S_EMPTY` goes to `S_DED` on a double error and to `S_SEC` on a single error.
- `S_SEC` goes to `S_DED` on a double error, and to `S_EMPTY` when its flag is cleared and no new single error arrives.
- `S_DED` goes to `S_SEC` or `S_EMPTY` when its flag is cleared, depending on whether the single flag survives.

A diagnostic path is used while checking is off. It copies raw check words from a chosen half of the cacheline into the syndrome fields.

Software uses a plain write strobe and a combinational read port. There are five word addresses: control, status, location and two syndrome words.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, all registers read 0 and both interrupts are low. The registers are control (addr 0), status (addr 1), location (addr 2) and syndrome words (addr 3, 4).
- R2: While control bit 0 (check enable) is 0, error events set no flag and leave location and syndromes unchanged.
- R3: A single error (any `evt_sec` bit) with no flag held does two things. It sets status bit 0. It also captures the location word: index in [10:0], set in [13:11], and in [17:14] the lane mask `evt_sec|evt_ded`. It captures the syndromes: lane 0 in addr 3 [9:0], lane 1 in addr 3 [19:10], lane 2 in addr 4 [9:0], lane 3 in addr 4 [19:10].
- R4: A single error arriving while either status flag is held leaves location and syndromes unchanged.
- R5: A double error (any `evt_ded` bit) sets status bit 1 and captures location and syndromes, even when a single-error capture is held.
- R6: A double error arriving while status bit 1 is already held leaves location and syndromes unchanged.
- R7: When single and double indications arrive in the same event, both flags are set and the event is captured as a double error.
- R8: Writing status with bit 0 or bit 1 set clears that flag. A 0 bit leaves its flag alone. An event in the same cycle as a clear is applied after the clear.
- R9: `irq_sec` equals status bit 0 AND control bit 1. `irq_ded` equals status bit 1 AND control bit 2.
- R10: Control bit 4 (diagnostic) can be 1 while check enable is 0. In that case a `diag_load` pulse writes raw check words into the four syndrome fields, and the flags and location are unchanged. The words come from `diag_chk` lanes 0–3 when control bit 3 is 0, and from lanes 4–7 when it is 1.
- R11: `diag_load` has no effect on the syndrome fields while check enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 3 | register write address |
| wr_data | input | 32 | register write data |
| rd_addr | input | 3 | register read address |
| rd_data | output | 32 | combinational read data |
| evt_valid | input | 1 | decoder result valid |
| evt_idx | input | 11 | half-cacheline index of the read |
| evt_set | input | 3 | set number of the read |
| evt_sec | input | 4 | per-lane corrected single error |
| evt_ded | input | 4 | per-lane detected double error |
| evt_syn | input | 40 | per-lane syndromes, lane n at [10n+9:10n] |
| diag_load | input | 1 | load seen from the diagnostic requester |
| diag_chk | input | 80 | raw check words of 8 lanes, lane n at [10n+9:10n] |
| irq_sec | output | 1 | single-error interrupt |
| irq_ded | output | 1 | double-error interrupt |

## Verification
The hardest situations to reach from the ports are those where a status clear and a new event land on the same clock edge. In these cases the decision to capture depends on the flag value after the clear, not before it. The stimulus table sets up a held single flag and then issues a clear together with a fresh single error. It also clears only the double flag while the single flag survives, so the machine must fall back to `S_SEC` and still refuse the next single error. The diagnostic path needs checking turned off and the diagnostic bit on at once. The directed tests reach it by rewriting control after the table and trying both half selections.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_SEC   = 2'd1,
        S_DED   = 2'd2
    } cap_state_e;

    localparam int unsigned A_CTRL = 0;
    localparam int unsigned A_STAT = 1;
    localparam int unsigned A_LOC  = 2;
    localparam int unsigned A_SYN0 = 3;

    localparam int unsigned C_ECC  = 0;
    localparam int unsigned C_SIE  = 1;
    localparam int unsigned C_DIE  = 2;
    localparam int unsigned C_HALF = 3;
    localparam int unsigned C_DIAG = 4;
    localparam int unsigned CTRL_W = 5;
endpackage

// File: rtl/ecc_log_regs.sv
module ecc_log_regs
    import ecc_log_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LOC_W  = 18,
    parameter int unsigned CHK_W  = 10,
    parameter int unsigned LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     sec_flag,
    input  logic                     ded_flag,
    input  logic [LOC_W-1:0]         loc,
    input  logic [LANES*CHK_W-1:0]   syn_flat,
    output logic                     ecc_on,
    output logic                     sec_ie,
    output logic                     ded_ie,
    output logic                     half_sel,
    output logic                     diag_en,
    output logic                     clr_sec,
    output logic                     clr_ded
);
    localparam int unsigned PAIRS  = LANES / 2;
    localparam int unsigned PAIR_W = 2 * CHK_W;

    logic [CTRL_W-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_CTRL)) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    assign ecc_on   = ctrl_q[C_ECC];
    assign sec_ie   = ctrl_q[C_SIE];
    assign ded_ie   = ctrl_q[C_DIE];
    assign half_sel = ctrl_q[C_HALF];
    assign diag_en  = ctrl_q[C_DIAG];

    assign clr_sec = wr_en && wr_addr == ADDR_W'(A_STAT) && wr_data[0];
    assign clr_ded = wr_en && wr_addr == ADDR_W'(A_STAT) && wr_data[1];

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CTRL)) begin
            rd_data[CTRL_W-1:0] = ctrl_q;
        end else if (rd_addr == ADDR_W'(A_STAT)) begin
            rd_data[1:0] = {ded_flag, sec_flag};
        end else if (rd_addr == ADDR_W'(A_LOC)) begin
            rd_data[LOC_W-1:0] = loc;
        end else begin
            for (int p = 0; p < PAIRS; p++) begin
                if (rd_addr == ADDR_W'(A_SYN0 + p)) begin
                    rd_data[PAIR_W-1:0] = syn_flat[p*PAIR_W +: PAIR_W];
                end
            end
        end
    end
endmodule

// File: rtl/ecc_log_fsm.sv
module ecc_log_fsm
    import ecc_log_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ecc_on,
    input  logic             evt_valid,
    input  logic [LANES-1:0] evt_sec,
    input  logic [LANES-1:0] evt_ded,
    input  logic             clr_sec,
    input  logic             clr_ded,
    output logic             sec_flag,
    output logic             ded_flag,
    output logic             cap_sec,
    output logic             cap_ded
);
    cap_state_e state_q, state_d;
    logic       sec_q, sec_d;
    logic       any_sec, any_ded, keep_sec, keep_ded;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            sec_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sec_q   <= sec_d;
        end
    end

    always_comb begin
        any_sec  = evt_valid && ecc_on && (|evt_sec);
        any_ded  = evt_valid && ecc_on && (|evt_ded);
        keep_sec = sec_q && !clr_sec;
        keep_ded = (state_q == S_DED) && !clr_ded;
        cap_ded  = any_ded && !keep_ded;
        cap_sec  = any_sec && !any_ded && !keep_sec && !keep_ded;
        sec_d    = keep_sec || any_sec;
        state_d  = state_q;
        unique case (state_q)
            S_EMPTY: begin
                if (any_ded)      state_d = S_DED;
                else if (any_sec) state_d = S_SEC;
            end
            S_SEC: begin
                if (any_ded)                  state_d = S_DED;
                else if (clr_sec && !any_sec) state_d = S_EMPTY;
            end
            S_DED: begin
                if (clr_ded && !any_ded)
                    state_d = sec_d ? S_SEC : S_EMPTY;
            end
            default: state_d = S_EMPTY;
        endcase
    end

    assign sec_flag = sec_q;
    assign ded_flag = (state_q == S_DED);

    p_sec_state_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEC) |-> sec_q);
    p_ded_overrides_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_on && evt_valid && (|evt_ded)) |=> (state_q == S_DED));
    p_both_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_on && evt_valid && (|evt_ded) && (|evt_sec)) |=> (sec_q && state_q == S_DED));
    p_ded_falls_on_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ded_flag) |-> $past(clr_ded));
    p_off_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_on && !sec_q) |=> !sec_q);
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
    parameter int unsigned LANES = 4,
    parameter int unsigned CHK_W = 10,
    parameter int unsigned IDX_W = 11,
    parameter int unsigned SET_W = 3,
    localparam int unsigned LOC_W = IDX_W + SET_W + LANES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap,
    input  logic [IDX_W-1:0]         evt_idx,
    input  logic [SET_W-1:0]         evt_set,
    input  logic [LANES-1:0]         evt_mask,
    input  logic [LANES*CHK_W-1:0]   evt_syn,
    input  logic                     diag_ld,
    input  logic                     half_sel,
    input  logic [2*LANES*CHK_W-1:0] diag_chk,
    output logic [LOC_W-1:0]         loc,
    output logic [LANES*CHK_W-1:0]   syn_flat
);
    logic [LOC_W-1:0] loc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   loc_q <= '0;
        else if (cap) loc_q <= {evt_mask, evt_set, evt_idx};
    end
    assign loc = loc_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CHK_W-1:0] syn_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                syn_q <= '0;
            end else if (cap) begin
                syn_q <= evt_syn[g*CHK_W +: CHK_W];
            end else if (diag_ld) begin
                syn_q <= half_sel ? diag_chk[(g+LANES)*CHK_W +: CHK_W]
                                  : diag_chk[g*CHK_W +: CHK_W];
            end
        end
        assign syn_flat[g*CHK_W +: CHK_W] = syn_q;
    end

    p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !diag_ld) |=> ($stable(loc_q) && $stable(syn_flat)));
    p_diag_keeps_loc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (diag_ld && !cap) |=> $stable(loc_q));
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
    import ecc_log_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned CHK_W  = 10,
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned SET_W  = 3,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     evt_valid,
    input  logic [IDX_W-1:0]         evt_idx,
    input  logic [SET_W-1:0]         evt_set,
    input  logic [LANES-1:0]         evt_sec,
    input  logic [LANES-1:0]         evt_ded,
    input  logic [LANES*CHK_W-1:0]   evt_syn,
    input  logic                     diag_load,
    input  logic [2*LANES*CHK_W-1:0] diag_chk,
    output logic                     irq_sec,
    output logic                     irq_ded
);
    localparam int unsigned LOC_W = IDX_W + SET_W + LANES;

    logic ecc_on, sec_ie, ded_ie, half_sel, diag_en;
    logic clr_sec, clr_ded, sec_flag, ded_flag, cap_sec, cap_ded, diag_ld;
    logic [LOC_W-1:0]       loc;
    logic [LANES*CHK_W-1:0] syn_flat;

    ecc_log_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOC_W(LOC_W),
                   .CHK_W(CHK_W), .LANES(LANES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_flag(sec_flag), .ded_flag(ded_flag), .loc(loc), .syn_flat(syn_flat),
        .ecc_on(ecc_on), .sec_ie(sec_ie), .ded_ie(ded_ie), .half_sel(half_sel),
        .diag_en(diag_en), .clr_sec(clr_sec), .clr_ded(clr_ded));

    ecc_log_fsm #(.LANES(LANES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ecc_on(ecc_on), .evt_valid(evt_valid),
        .evt_sec(evt_sec), .evt_ded(evt_ded), .clr_sec(clr_sec), .clr_ded(clr_ded),
        .sec_flag(sec_flag), .ded_flag(ded_flag), .cap_sec(cap_sec), .cap_ded(cap_ded));

    assign diag_ld = diag_en && !ecc_on && diag_load;

    ecc_log_capture #(.LANES(LANES), .CHK_W(CHK_W), .IDX_W(IDX_W),
                      .SET_W(SET_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .cap(cap_sec || cap_ded), .evt_idx(evt_idx),
        .evt_set(evt_set), .evt_mask(evt_sec | evt_ded), .evt_syn(evt_syn),
        .diag_ld(diag_ld), .half_sel(half_sel), .diag_chk(diag_chk),
        .loc(loc), .syn_flat(syn_flat));

    assign irq_sec = sec_flag && sec_ie;
    assign irq_ded = ded_flag && ded_ie;

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ded) |-> ded_ie);
    p_diag_only_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ecc_on && !cap_sec && !cap_ded) |=> $stable(syn_flat));
endmodule

// File: tb/sim_ecc_err_logger.sv
module sim_ecc_err_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        evt_valid = 1'b0;
    logic [10:0] evt_idx = '0;
    logic [2:0]  evt_set = '0;
    logic [3:0]  evt_sec = '0;
    logic [3:0]  evt_ded = '0;
    logic [39:0] evt_syn = '0;
    logic        diag_load = 1'b0;
    logic [79:0] diag_chk = '0;
    logic        irq_sec, irq_ded;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ecc_err_logger u0 (.*);

    // {clr[1:0], sec[3:0], ded[3:0], idx[10:0], set[2:0], exp_stat[1:0], src[3:0]}
    localparam logic [29:0] VEC [10] = '{
        {2'b00, 4'b0001, 4'b0000, 11'd5,  3'd1, 2'b01, 4'd0}, // R3
        {2'b00, 4'b0100, 4'b0000, 11'd9,  3'd2, 2'b01, 4'd0}, // R4
        {2'b00, 4'b0000, 4'b0010, 11'd20, 3'd3, 2'b11, 4'd2}, // R5
        {2'b00, 4'b0000, 4'b1000, 11'd30, 3'd4, 2'b11, 4'd2}, // R6
        {2'b11, 4'b0000, 4'b0000, 11'd0,  3'd0, 2'b00, 4'd2}, // R8
        {2'b00, 4'b0011, 4'b1000, 11'd40, 3'd5, 2'b11, 4'd5}, // R7
        {2'b10, 4'b0000, 4'b0000, 11'd0,  3'd0, 2'b01, 4'd5}, // R8
        {2'b00, 4'b0001, 4'b0000, 11'd50, 3'd6, 2'b01, 4'd5}, // R4
        {2'b01, 4'b0010, 4'b0000, 11'd60, 3'd6, 2'b01, 4'd8}, // R8
        {2'b00, 4'b0000, 4'b0000, 11'd0,  3'd0, 2'b01, 4'd8}  // R8
    };

    function automatic logic [9:0] syn_of(int k, int l);
        return 10'((k * 97 + l * 211 + 13) % 1024);
    endfunction

    function automatic logic [9:0] chk_of(int j, int base);
        return 10'(base + 3 * j);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic evt(logic [1:0] clr, logic [3:0] s, logic [3:0] dd,
                       logic [10:0] idx, logic [2:0] st, int k);
        @(negedge clk);
        evt_valid = (s != 0) || (dd != 0);
        evt_sec = s; evt_ded = dd; evt_idx = idx; evt_set = st;
        for (int l = 0; l < 4; l++) evt_syn[l*10 +: 10] = syn_of(k, l);
        wr_en = (clr != 0); wr_addr = 3'd1; wr_data = {30'b0, clr};
        @(negedge clk);
        evt_valid = 1'b0; evt_sec = '0; evt_ded = '0; wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, locx, slo, shi, saved_loc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            check("R1 reset reg", d, 32'd0);
        end
        check("R1 irq", {30'b0, irq_ded, irq_sec}, 32'd0);

        wr(3'd0, 32'h07);
        for (int i = 0; i < 10; i++) begin
            logic [29:0] v, sv;
            int src;
            v = VEC[i];
            evt(v[29:28], v[27:24], v[23:20], v[19:9], v[8:6], i);
            src = int'(v[3:0]);
            sv = VEC[src];
            locx = {14'b0, sv[27:24] | sv[23:20], sv[8:6], sv[19:9]};
            slo = {12'b0, syn_of(src, 1), syn_of(src, 0)};
            shi = {12'b0, syn_of(src, 3), syn_of(src, 2)};
            rd(3'd1, d); check("R3/R4/R5/R6/R7/R8 status", d, {30'b0, v[5:4]});
            rd(3'd2, d); check("R3/R4/R5/R6/R7 location", d, locx);
            rd(3'd3, d); check("R3 syndrome lanes 0,1", d, slo);
            rd(3'd4, d); check("R3 syndrome lanes 2,3", d, shi);
            check("R9 irqs", {30'b0, irq_ded, irq_sec}, {30'b0, v[5:4]});
        end

        // R2: checking off, events ignored
        wr(3'd1, 32'h3);
        wr(3'd0, 32'h06);
        rd(3'd2, saved_loc);
        evt(2'b00, 4'b0001, 4'b0100, 11'd77, 3'd7, 11);
        rd(3'd1, d); check("R2 status unchanged", d, 32'd0);
        rd(3'd2, d); check("R2 location unchanged", d, saved_loc);
        rd(3'd3, d); check("R2 syndrome unchanged", d, {12'b0, syn_of(8, 1), syn_of(8, 0)});

        // R9: enables gate interrupts
        wr(3'd0, 32'h01);
        evt(2'b00, 4'b0001, 4'b0010, 11'd3, 3'd0, 12);
        rd(3'd1, d); check("R7 both flags", d, 32'd3);
        check("R9 irqs masked", {30'b0, irq_ded, irq_sec}, 32'd0);
        wr(3'd0, 32'h03);
        check("R9 sec only enabled", {30'b0, irq_ded, irq_sec}, 32'd1);
        wr(3'd0, 32'h05);
        check("R9 ded only enabled", {30'b0, irq_ded, irq_sec}, 32'd2);

        // R10: diagnostic latch, first half then second half
        for (int j = 0; j < 8; j++) diag_chk[j*10 +: 10] = chk_of(j, 700);
        rd(3'd2, saved_loc);
        wr(3'd0, 32'h10);
        @(negedge clk); diag_load = 1'b1; @(negedge clk); diag_load = 1'b0;
        rd(3'd3, d); check("R10 half0 lanes 0,1", d, {12'b0, chk_of(1, 700), chk_of(0, 700)});
        rd(3'd4, d); check("R10 half0 lanes 2,3", d, {12'b0, chk_of(3, 700), chk_of(2, 700)});
        rd(3'd1, d); check("R10 flags unchanged", d, 32'd3);
        rd(3'd2, d); check("R10 location unchanged", d, saved_loc);
        wr(3'd0, 32'h18);
        @(negedge clk); diag_load = 1'b1; @(negedge clk); diag_load = 1'b0;
        rd(3'd3, d); check("R10 half1 lanes 4,5", d, {12'b0, chk_of(5, 700), chk_of(4, 700)});
        rd(3'd4, d); check("R10 half1 lanes 6,7", d, {12'b0, chk_of(7, 700), chk_of(6, 700)});

        // R11: diag load ignored while checking is on
        wr(3'd0, 32'h11);
        for (int j = 0; j < 8; j++) diag_chk[j*10 +: 10] = chk_of(j, 100);
        @(negedge clk); diag_load = 1'b1; @(negedge clk); diag_load = 1'b0;
        rd(3'd3, d); check("R11 syndrome unchanged", d, {12'b0, chk_of(5, 700), chk_of(4, 700)});
        rd(3'd0, d); check("R1 control readback", d, 32'h11);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule